// File: doc/BRIEF.md
# GPIO Bank Interrupt Controller

This block is one bank of general-purpose pins (up to 16) with a trigger detector on every pin and a small register file on a plain word-addressed read/write bus. Software writes the bank's output data and sets each pin's direction. It enables interrupts per pin and picks a trigger condition for each pin: rising edge, falling edge, both edges, high level or low level. Each pin can also be masked and unmasked through a pair of write-one registers.

Every input goes through a two-flop synchroniser. A detector compares the synchronised value with its value one clock earlier, or simply tests its level. A detected event on an enabled pin latches a status bit. Status bits that are enabled and not masked are combined into one registered, active-high interrupt line. The host reads the status register to find which pins fired, then acknowledges each one by writing a 1 to its bit in the acknowledge register.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads 0 at every address, `gpio_o`, `gpio_oe_o` and `irq_o` are 0, and all pins are inputs.
- R2: Address 0 holds the output data and address 1 holds the direction, where a 1 makes the pin an output. Both are written whole, read back, and drive `gpio_o` and `gpio_oe_o` directly.
- R3: Each pin has a 3-bit trigger code: 000 falling edge, 001 rising edge, 010 low level, 011 high level, and any code with bit 2 set means both edges. Pins 0 to 7 sit in address 5 at bits [4p+2:4p]. Pins 8 to 15 sit in address 6 at bits [4(p-8)+2:4(p-8)]. Bit 4p+3 of each slot reads 0.
- R4: A pin value first sampled at clock edge n is seen by the detector at edge n+2. A matching event sets the status bit (address 7, bit p) at that edge.
- R5: The interrupt enable register (address 2) gates detection. While a pin's enable bit is 0, its status bit never sets, and a status bit already set stays set.
- R6: Writing 1s to address 3 sets those mask bits. Writing 1s to address 4 clears them. Zero bits in either write leave the mask unchanged. Address 3 reads back the mask, and address 4 reads 0.
- R7: Writing 1s to address 8 clears those status bits, and address 8 reads 0. If an event on the same pin falls in the same cycle as the acknowledge, the status bit stays set, so a level that persists keeps its status bit set.
- R8: `irq_o` is the OR over all pins of (status AND enable AND NOT mask), registered, so it changes one edge after the status, enable or mask change that causes it.
- R9: Bits at or above NPIN read 0 and ignore writes. Mode slots of pins at or above NPIN read 0. Addresses 9 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| gpio_i | input | NPIN | Raw pin inputs, asynchronous |
| gpio_o | output | NPIN | Output data |
| gpio_oe_o | output | NPIN | Direction, 1 = output |
| irq_o | output | 1 | Registered interrupt line |

## Verification
Two functions can collide on one pin in a single cycle: an acknowledge write to address 8 and a fresh event from the detector. The bench provokes this by acknowledging a high-level pin while its input is held high, and again during a long run of random pin values mixed with random writes, including acknowledges. A cycle-accurate model in the bench keeps its own delay line of sampled inputs and applies set-over-clear. It is compared against the read data, the pin outputs and `irq_o` after every edge. A second overlap, a mask write landing while a status bit is pending, is judged through the one-edge lag of `irq_o`.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int DATA_W        = 32;
  localparam int ADDR_W        = 4;
  localparam int MODE_W        = 3;
  localparam int SLOT_W        = 4;
  localparam int SLOTS_PER_REG = DATA_W / SLOT_W;
  localparam int MAX_PIN       = 2 * SLOTS_PER_REG;
  localparam int BOTH_BIT      = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_DOUT   = 4'd0,
    A_DIR    = 4'd1,
    A_IEN    = 4'd2,
    A_MASK   = 4'd3,
    A_UNMASK = 4'd4,
    A_MODE0  = 4'd5,
    A_MODE1  = 4'd6,
    A_STS    = 4'd7,
    A_ACK    = 4'd8
  } reg_addr_e;

  localparam logic [1:0] TRIG_FALL = 2'b00;
  localparam logic [1:0] TRIG_RISE = 2'b01;
  localparam logic [1:0] TRIG_LOW  = 2'b10;
  localparam logic [1:0] TRIG_HIGH = 2'b11;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl_o  = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_trig_det.sv
module gpio_trig_det import gpio_irq_pkg::*; #(
  parameter int NPIN = 16
) (
  input  logic [NPIN-1:0]             lvl_i,
  input  logic [NPIN-1:0]             prev_i,
  input  logic [NPIN-1:0]             ien_i,
  input  logic [NPIN-1:0][MODE_W-1:0] mode_i,
  output logic [NPIN-1:0]             evt_o
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic hit;
    always_comb begin
      if (mode_i[p][BOTH_BIT]) begin
        hit = lvl_i[p] ^ prev_i[p];
      end else begin
        case (mode_i[p][1:0])
          TRIG_FALL: hit = ~lvl_i[p] & prev_i[p];
          TRIG_RISE: hit = lvl_i[p] & ~prev_i[p];
          TRIG_LOW:  hit = ~lvl_i[p];
          default:   hit = lvl_i[p];
        endcase
      end
    end
    assign evt_o[p] = hit & ien_i[p];
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs import gpio_irq_pkg::*; #(
  parameter int NPIN = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  input  logic [NPIN-1:0]             evt_i,
  output logic [NPIN-1:0]             dout_o,
  output logic [NPIN-1:0]             dir_o,
  output logic [NPIN-1:0]             ien_o,
  output logic [NPIN-1:0]             mask_o,
  output logic [NPIN-1:0][MODE_W-1:0] mode_o,
  output logic [NPIN-1:0]             sts_o,
  output logic [NPIN-1:0]             sts_clr_o,
  output logic [NPIN-1:0]             mask_set_o,
  output logic                        irq_o
);
  logic [NPIN-1:0] wsel, mask_clr;
  logic [NPIN-1:0] dout_q, dir_q, ien_q, mask_q, sts_q;
  logic            irq_q;
  logic [DATA_W-1:0] mode0_rd, mode1_rd;
  logic unused_wdata;

  assign wsel         = wdata_i[NPIN-1:0];
  assign unused_wdata = ^wdata_i;

  assign sts_clr_o  = (we_i && addr_i == A_ACK)    ? wsel : '0;
  assign mask_set_o = (we_i && addr_i == A_MASK)   ? wsel : '0;
  assign mask_clr   = (we_i && addr_i == A_UNMASK) ? wsel : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      mask_q <= '0;
      sts_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (we_i && addr_i == A_DOUT) dout_q <= wsel;
      if (we_i && addr_i == A_DIR)  dir_q  <= wsel;
      if (we_i && addr_i == A_IEN)  ien_q  <= wsel;
      mask_q <= (mask_q | mask_set_o) & ~mask_clr;
      // new event wins over a same-cycle acknowledge
      sts_q  <= (sts_q & ~sts_clr_o) | evt_i;
      irq_q  <= |(sts_q & ien_q & ~mask_q);
    end
  end

  // per-pin 3-bit trigger code in a 4-bit slot, split over two registers
  for (genvar p = 0; p < NPIN; p++) begin : g_mode
    localparam reg_addr_e MADDR = (p < SLOTS_PER_REG) ? A_MODE0 : A_MODE1;
    localparam int        MOFS  = SLOT_W * (p % SLOTS_PER_REG);
    logic [MODE_W-1:0] mode_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mode_q <= '0;
      else if (we_i && addr_i == MADDR) mode_q <= wdata_i[MOFS +: MODE_W];
    end
    assign mode_o[p] = mode_q;
  end

  always_comb begin
    mode0_rd = '0;
    mode1_rd = '0;
    for (int p = 0; p < NPIN; p++) begin
      if (p < SLOTS_PER_REG) mode0_rd[SLOT_W*(p%SLOTS_PER_REG) +: MODE_W] = mode_o[p];
      else                   mode1_rd[SLOT_W*(p%SLOTS_PER_REG) +: MODE_W] = mode_o[p];
    end
  end

  always_comb begin
    case (addr_i)
      A_DOUT:  rdata_o = DATA_W'(dout_q);
      A_DIR:   rdata_o = DATA_W'(dir_q);
      A_IEN:   rdata_o = DATA_W'(ien_q);
      A_MASK:  rdata_o = DATA_W'(mask_q);
      A_MODE0: rdata_o = mode0_rd;
      A_MODE1: rdata_o = mode1_rd;
      A_STS:   rdata_o = DATA_W'(sts_q);
      default: rdata_o = '0;
    endcase
  end

  assign dout_o = dout_q;
  assign dir_o  = dir_q;
  assign ien_o  = ien_q;
  assign mask_o = mask_q;
  assign sts_o  = sts_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank import gpio_irq_pkg::*; #(
  parameter int NPIN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [3:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [NPIN-1:0]   gpio_i,
  output logic [NPIN-1:0]   gpio_o,
  output logic [NPIN-1:0]   gpio_oe_o,
  output logic              irq_o
);
  logic [NPIN-1:0]             lvl_w, prev_w, evt_w;
  logic [NPIN-1:0]             ien_w, mask_w, sts_w, sts_clr_w, mask_set_w;
  logic [NPIN-1:0][MODE_W-1:0] mode_w;

  gpio_in_sync #(.W(NPIN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (gpio_i),
    .lvl_o  (lvl_w),
    .prev_o (prev_w)
  );

  gpio_trig_det #(.NPIN(NPIN)) u_det (
    .lvl_i  (lvl_w),
    .prev_i (prev_w),
    .ien_i  (ien_w),
    .mode_i (mode_w),
    .evt_o  (evt_w)
  );

  gpio_irq_regs #(.NPIN(NPIN)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (bus_rdata_o),
    .evt_i      (evt_w),
    .dout_o     (gpio_o),
    .dir_o      (gpio_oe_o),
    .ien_o      (ien_w),
    .mask_o     (mask_w),
    .mode_o     (mode_w),
    .sts_o      (sts_w),
    .sts_clr_o  (sts_clr_w),
    .mask_set_o (mask_set_w),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk import gpio_irq_pkg::*; #(
  parameter int NPIN = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        bus_addr_i,
  input logic [31:0]       bus_rdata_i,
  input logic              irq_i,
  input logic [NPIN-1:0]   sts_i,
  input logic [NPIN-1:0]   ien_i,
  input logic [NPIN-1:0]   mask_i,
  input logic [NPIN-1:0]   evt_i,
  input logic [NPIN-1:0]   sts_clr_i,
  input logic [NPIN-1:0]   mask_set_i
);
  // R8
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(sts_i & ien_i & ~mask_i)) |=> irq_i);

  // R8
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(sts_i & ien_i & ~mask_i)) |=> !irq_i);

  // R5
  sts_needs_ien_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_i & ~$past(sts_i) & ~$past(ien_i)) == '0);

  // R7
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_clr_i != '0) |=> ((sts_i & $past(sts_clr_i) & ~$past(evt_i)) == '0));

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((sts_i & $past(evt_i)) == $past(evt_i)));

  // R6
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_set_i != '0) |=> ((mask_i & $past(mask_set_i)) == $past(mask_set_i)));

  // R9
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i inside {A_DOUT, A_DIR, A_IEN, A_MASK, A_STS}) |-> ((bus_rdata_i >> NPIN) == '0));

  // R3
  slot_msb_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == A_MODE0 || bus_addr_i == A_MODE1) |-> ((bus_rdata_i & 32'h8888_8888) == '0));
endmodule

bind gpio_irq_bank gpio_irq_chk #(.NPIN(NPIN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_i (bus_rdata_o),
  .irq_i       (irq_o),
  .sts_i       (sts_w),
  .ien_i       (ien_w),
  .mask_i      (mask_w),
  .evt_i       (evt_w),
  .sts_clr_i   (sts_clr_w),
  .mask_set_i  (mask_set_w)
);

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPIN = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            we = 1'b0;
  logic [3:0]      addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NPIN-1:0] gpio_in = '0;
  logic [NPIN-1:0] gpio_out, gpio_oe;
  logic            irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank #(.NPIN(NPIN)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .bus_we_i (we), .bus_addr_i (addr),
    .bus_wdata_i (wdata), .bus_rdata_o (rdata), .gpio_i (gpio_in),
    .gpio_o (gpio_out), .gpio_oe_o (gpio_oe), .irq_o (irq)
  );

  // ---------------- reference model ----------------
  logic [NPIN-1:0] m_dout, m_dir, m_ien, m_mask, m_sts, m_evt, m_s, m_p, m_w;
  int              m_mode [NPIN];
  logic            m_irq;
  logic [NPIN-1:0] hist [$];
  bit              h;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dout = '0; m_dir = '0; m_ien = '0; m_mask = '0; m_sts = '0; m_irq = 1'b0;
      foreach (m_mode[i]) m_mode[i] = 0;
      hist = {};
      repeat (3) hist.push_back('0);
    end else begin
      m_s = hist[1];
      m_p = hist[2];
      m_evt = '0;
      for (int i = 0; i < NPIN; i++) begin
        if (m_mode[i] >= 4) h = (m_s[i] != m_p[i]);
        else if (m_mode[i] == 0) h = !m_s[i] && m_p[i];
        else if (m_mode[i] == 1) h = m_s[i] && !m_p[i];
        else if (m_mode[i] == 2) h = !m_s[i];
        else h = m_s[i];
        if (h && m_ien[i]) m_evt[i] = 1'b1;
      end
      m_irq = |(m_sts & m_ien & ~m_mask);
      m_w = wdata[NPIN-1:0];
      if (we && addr == 8) m_sts = m_sts & ~m_w;
      m_sts = m_sts | m_evt;
      if (we) begin
        case (addr)
          0: m_dout = m_w;
          1: m_dir = m_w;
          2: m_ien = m_w;
          3: m_mask = m_mask | m_w;
          4: m_mask = m_mask & ~m_w;
          5: for (int i = 0; i < NPIN && i < 8; i++) m_mode[i] = int'((wdata >> (4*i)) & 32'h7);
          6: for (int i = 8; i < NPIN; i++) m_mode[i] = int'((wdata >> (4*(i-8))) & 32'h7);
          default: ;
        endcase
      end
      hist.push_front(gpio_in);
      void'(hist.pop_back());
    end
  end

  function automatic logic [31:0] model_rd(input logic [3:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      0: r = 32'(m_dout);
      1: r = 32'(m_dir);
      2: r = 32'(m_ien);
      3: r = 32'(m_mask);
      5: for (int i = 0; i < NPIN && i < 8; i++) r |= 32'(m_mode[i]) << (4*i);
      6: for (int i = 8; i < NPIN; i++) r |= 32'(m_mode[i]) << (4*(i-8));
      7: r = 32'(m_sts);
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string req_of(input logic [3:0] a);
    case (a)
      0, 1: return "R2";
      2: return "R5";
      3, 4: return "R6";
      5, 6: return "R3";
      7, 8: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string msg);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, msg, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rdata, model_rd(addr), req_of(addr), "cycle read");
      chk(32'(irq), 32'(m_irq), "R8", "cycle irq");
      chk(32'(gpio_out), 32'(m_dout), "R2", "cycle gpio_o");
      chk(32'(gpio_oe), 32'(m_dir), "R2", "cycle gpio_oe_o");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] m, input logic [31:0] e,
                        input string tag, input string msg);
    addr = a;
    @(negedge clk);
    chk(rdata & m, e, tag, msg);
    @(posedge clk); #1;
  endtask

  task automatic irq_chk(input logic e, input string tag, input string msg);
    @(negedge clk);
    chk(32'(irq), 32'(e), tag, msg);
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    for (int a = 0; a < 9; a++) rd_chk(4'(a), 32'hFFFF_FFFF, 32'h0, "R1", "reset read");
    irq_chk(1'b0, "R1", "reset irq");
    chk(32'(gpio_oe), 32'h0, "R1", "reset direction");

    // R2 / R9 data and direction
    wr(0, 32'hFFFF_FABC);
    rd_chk(0, 32'hFFFF_FFFF, 32'h0000_0ABC, "R9", "dout upper bits");
    chk(32'(gpio_out), 32'h0ABC, "R2", "gpio_o drive");
    wr(1, 32'h0000_00F0);
    rd_chk(1, 32'hFFFF_FFFF, 32'h0000_00F0, "R2", "direction readback");
    chk(32'(gpio_oe), 32'h00F0, "R2", "gpio_oe_o drive");
    wr(2, 32'hFFFF_FFFF);
    rd_chk(2, 32'hFFFF_FFFF, 32'h0000_0FFF, "R9", "ien upper bits");
    wr(2, 32'h0);

    // R3 / R9 mode slots
    wr(5, 32'hFFFF_FFFF);
    rd_chk(5, 32'hFFFF_FFFF, 32'h7777_7777, "R3", "mode0 slot msb");
    wr(6, 32'hFFFF_FFFF);
    rd_chk(6, 32'hFFFF_FFFF, 32'h0000_7777, "R9", "mode1 unused pins");
    rd_chk(9, 32'hFFFF_FFFF, 32'h0, "R9", "unused address");

    // R6 mask set / clear
    wr(3, 32'h5);
    wr(3, 32'h2);
    rd_chk(3, 32'hFFFF_FFFF, 32'h7, "R6", "mask set accumulates");
    wr(4, 32'h1);
    wr(4, 32'h0);
    rd_chk(3, 32'hFFFF_FFFF, 32'h6, "R6", "mask clear and zero write");
    rd_chk(4, 32'hFFFF_FFFF, 32'h0, "R6", "unmask reads zero");
    wr(4, 32'hFFF);

    // pins: 0 rise, 1 rise, 2 high, 3 low, 4 fall, 5 both
    wr(6, 32'h0);
    wr(5, 32'h0040_2311);
    wr(2, 32'h35);

    // R4 latency on pin 0
    gpio_in[0] = 1'b1;
    addr = 7;
    idle(2);
    @(negedge clk); chk(32'(rdata[0]), 0, "R4", "status before detect edge");
    @(posedge clk); #1;
    @(negedge clk); chk(32'(rdata[0]), 1, "R4", "status at detect edge");
    chk(32'(irq), 0, "R8", "irq lags status");
    @(posedge clk); #1;
    irq_chk(1'b1, "R8", "irq one edge after status");
    wr(8, 32'h1);
    rd_chk(7, 32'h1, 32'h0, "R7", "ack clears edge status");

    // R5 disabled pin 1
    gpio_in[1] = 1'b1;
    idle(4);
    rd_chk(7, 32'h2, 32'h0, "R5", "no latch while disabled");

    // R7 level re-set and same-cycle collision on pin 2
    gpio_in[2] = 1'b1;
    idle(4);
    rd_chk(7, 32'h4, 32'h4, "R3", "high level latches");
    wr(8, 32'h4);
    rd_chk(7, 32'h4, 32'h4, "R7", "set wins over ack");
    gpio_in[2] = 1'b0;
    idle(3);
    wr(8, 32'h4);
    rd_chk(7, 32'h4, 32'h0, "R7", "ack after level gone");

    // R8 mask gating with pin 4 falling edge
    gpio_in[4] = 1'b1;
    idle(4);
    rd_chk(7, 32'h10, 32'h0, "R3", "fall mode ignores rise");
    gpio_in[4] = 1'b0;
    idle(4);
    rd_chk(7, 32'h10, 32'h10, "R3", "fall mode latches");
    irq_chk(1'b1, "R8", "irq with pending fall");
    wr(3, 32'h10);
    idle(1);
    irq_chk(1'b0, "R8", "irq masked");
    wr(4, 32'h10);
    idle(1);
    irq_chk(1'b1, "R8", "irq unmasked");
    wr(8, 32'h10);

    // both edges on pin 5
    gpio_in[5] = 1'b1;
    idle(4);
    rd_chk(7, 32'h20, 32'h20, "R3", "both mode rise");
    wr(8, 32'h20);
    gpio_in[5] = 1'b0;
    idle(4);
    rd_chk(7, 32'h20, 32'h20, "R3", "both mode fall");
    wr(8, 32'h20);

    // low level on pin 3, then disable and ack
    wr(2, 32'h3D);
    idle(2);
    rd_chk(7, 32'h8, 32'h8, "R3", "low level latches");
    wr(2, 32'h35);
    rd_chk(7, 32'h8, 32'h8, "R5", "status held after disable");
    wr(8, 32'h8);
    rd_chk(7, 32'h8, 32'h0, "R5", "no re-set while disabled");

    // random mix, judged cycle by cycle against the model
    for (int n = 0; n < 600; n++) begin
      gpio_in = NPIN'($urandom);
      we = ($urandom % 3) == 0;
      addr = 4'($urandom % 10);
      wdata = $urandom;
      @(posedge clk); #1;
    end
    we = 1'b0;
    idle(4);

    finish_run();
  end
endmodule